// File: doc/BRIEF.md
# PWM Generator Parameter Shadow and Commit Controller

This block holds the configuration of one PWM generator in two copies: a shadow copy that bus writes land in, and an active copy that the waveform logic reads. There are eight tracked parameters: period load, compare A, compare B, output action A, output action B, dead-band control, rising-edge delay and falling-edge delay. For each parameter, a mode field decides when a written value moves from the shadow copy to the active copy. It can move at once. It can move at the next counter-zero strobe from the generator. Or it can move at the first counter zero that comes with or after a global update request.

Software writes a parameter by putting its select code and data on the write port for one cycle. The mode fields sit in one more register in the same select space. The generator supplies a one-cycle `cnt_zero` strobe. A peripheral-level sequencer supplies `gsync_req` and receives `gsync_ack`, so that several generators can switch parameter sets on the same period boundary. A per-parameter pending flag shows that a value is waiting to be committed.

Top module: `pwmsh_ctrl`

## Requirements
- R1: After reset every active value is 0, every pending flag is 0, `gsync_ack` is 0 and every mode field is 0. With mode 0, the three counter parameters commit at the next zero and the five waveform parameters commit immediately.
- R2: Select codes 0..7 address, in this order, load, compare A, compare B, action A, action B, dead-band control, rising delay and falling delay. Code 8 addresses the mode register. Codes 9..15 are ignored, and a write with one of them changes no output.
- R3: A waveform parameter with 2-bit mode code 0 or 1 (code 1 is reserved and acts as code 0) shows the written data on its active output in the cycle after the write, and its pending flag stays 0.
- R4: In local mode (2-bit code 2, or 1-bit code 0), a write sets the pending flag in the next cycle and leaves the active value alone. The first cycle with `cnt_zero` high commits the shadow value, which is visible in the next cycle, and clears the pending flag.
- R5: In global mode (2-bit code 3, or 1-bit code 1), a pending value survives any number of counter zeros until a global request has been seen. It then commits on the first `cnt_zero` cycle that comes in the request cycle or later.
- R6: Mode register layout: bits [1:0] action A, [3:2] action B, [5:4] dead-band control, [7:6] rising delay, [9:8] falling delay, bit 10 load, bit 11 compare A, bit 12 compare B. A mode write takes effect from the next cycle.
- R7: When a parameter is written again before its commit, the later data replaces the earlier data, and only the last value is committed.
- R8: A write in the same cycle as a `cnt_zero` that is allowed to commit that parameter commits the new data in that cycle.
- R9: `gsync_req` sets a request latch. `gsync_ack` is high in the cycle after each `cnt_zero` cycle in which the latch was set or `gsync_req` was high, and that zero clears the latch. A later global commit needs a new request.
- R10: A value still pending when its mode is changed to immediate commits at the next counter zero.
- R11: Active values and pending flags change only in the cycle after a write or a counter zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_sel | input | SEL_W | Register select code |
| wr_data | input | DW | Write data |
| cnt_zero | input | 1 | Generator counter-zero strobe |
| gsync_req | input | 1 | Global update request |
| gsync_ack | output | 1 | Pulse marking consumption of a global request |
| act_vals | output | 8*DW | Active parameter values, parameter i in bits [i*DW +: DW] |
| pend_flags | output | 8 | Pending flag per parameter |

## Verification
Two pairs of events can fall in the same cycle, and both are provoked on purpose. In the first, a parameter write lands in the same cycle as a committing counter zero, and the bench expects the new data rather than the older shadow. In the second, a global request arrives in the very cycle of the zero, and the bench expects the commit and the acknowledge at once, with no wait for a further zero. A behavioural reference model in the bench judges every cycle of these directed collisions and of a long random mix in which writes, zeros, requests and mode changes overlap freely.

// File: rtl/pwmsh_pkg.sv
package pwmsh_pkg;
  localparam int N_SHORT   = 3;               // counter parameters, 1-bit mode
  localparam int N_LONG    = 5;               // waveform parameters, 2-bit mode
  localparam int NPARAM    = N_SHORT + N_LONG;
  localparam int LONG_BITS = 2 * N_LONG;
  localparam int MODE_W    = LONG_BITS + N_SHORT;
  localparam int SEL_MODE  = NPARAM;

  typedef enum logic [1:0] {
    CLS_IMM    = 2'd0,
    CLS_LOCAL  = 2'd1,
    CLS_GLOBAL = 2'd2
  } cls_e;
endpackage

// File: rtl/pwmsh_mode_reg.sv
module pwmsh_mode_reg
  import pwmsh_pkg::*;
#(
  parameter int SEL_W = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [SEL_W-1:0]    wr_sel,
  input  logic [MODE_W-1:0]   wr_mode,
  output logic [MODE_W-1:0]   mode_q,
  output logic [2*NPARAM-1:0] cls_vec
);
  logic              mode_we;
  logic [MODE_W-1:0] mode_n;

  always_comb begin
    mode_we = wr_en && (wr_sel == SEL_W'(SEL_MODE));
    mode_n  = mode_we ? wr_mode : mode_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mode_q <= '0;
    else if (mode_we) mode_q <= mode_n;
  end

  // counter parameters take bits above the 2-bit fields
  for (genvar g = 0; g < NPARAM; g++) begin : g_dec
    if (g < N_SHORT) begin : g_short
      assign cls_vec[2*g +: 2] = mode_q[LONG_BITS + g] ? CLS_GLOBAL : CLS_LOCAL;
    end else begin : g_long
      logic [1:0] code;
      assign code = mode_q[2*(g-N_SHORT) +: 2];
      always_comb begin
        case (code)
          2'd2:    cls_vec[2*g +: 2] = CLS_LOCAL;
          2'd3:    cls_vec[2*g +: 2] = CLS_GLOBAL;
          default: cls_vec[2*g +: 2] = CLS_IMM;   // 0 and reserved 1
        endcase
      end
    end
  end
endmodule

// File: rtl/pwmsh_gsync.sv
module pwmsh_gsync (
  input  logic clk,
  input  logic rst_n,
  input  logic cnt_zero,
  input  logic gsync_req,
  output logic g_armed,
  output logic gsync_ack
);
  logic greq_q, greq_n, fire;

  always_comb begin
    g_armed = greq_q | gsync_req;
    fire    = cnt_zero & g_armed;
    greq_n  = fire ? 1'b0 : g_armed;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      greq_q    <= 1'b0;
      gsync_ack <= 1'b0;
    end else begin
      greq_q    <= greq_n;
      gsync_ack <= fire;
    end
  end
endmodule

// File: rtl/pwmsh_slot.sv
module pwmsh_slot
  import pwmsh_pkg::*;
#(
  parameter int DW    = 16,
  parameter int SEL_W = 4,
  parameter int IDX   = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [SEL_W-1:0] wr_sel,
  input  logic [DW-1:0] wr_data,
  input  logic          cnt_zero,
  input  logic          g_armed,
  input  cls_e          cls,
  output logic [DW-1:0] act_q,
  output logic          pend_q
);
  logic [DW-1:0] shd_q, shd_n, act_n;
  logic          hit, eff_pend, allow, commit, pend_n, act_we;

  always_comb begin
    hit      = wr_en && (wr_sel == SEL_W'(IDX));
    shd_n    = hit ? wr_data : shd_q;
    eff_pend = pend_q | hit;
    allow    = (cls == CLS_GLOBAL) ? g_armed : 1'b1;
    commit   = cnt_zero && eff_pend && allow;
    act_n    = act_q;
    pend_n   = eff_pend;
    act_we   = 1'b0;
    if (hit && cls == CLS_IMM) begin
      act_n  = wr_data;
      pend_n = 1'b0;
      act_we = 1'b1;
    end else if (commit) begin
      act_n  = shd_n;          // bypass: same-cycle write wins
      pend_n = 1'b0;
      act_we = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shd_q  <= '0;
      act_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      if (hit)    shd_q <= shd_n;
      if (act_we) act_q <= act_n;
      pend_q <= pend_n;
    end
  end
endmodule

// File: rtl/pwmsh_ctrl.sv
module pwmsh_ctrl
  import pwmsh_pkg::*;
#(
  parameter int DW    = 16,
  parameter int SEL_W = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [SEL_W-1:0]     wr_sel,
  input  logic [DW-1:0]        wr_data,
  input  logic                 cnt_zero,
  input  logic                 gsync_req,
  output logic                 gsync_ack,
  output logic [NPARAM*DW-1:0] act_vals,
  output logic [NPARAM-1:0]    pend_flags
);
  logic [MODE_W-1:0]   mode_q;
  logic [2*NPARAM-1:0] cls_vec;
  logic                g_armed;

  pwmsh_mode_reg #(.SEL_W(SEL_W)) mode_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_sel  (wr_sel),
    .wr_mode (wr_data[MODE_W-1:0]),
    .mode_q  (mode_q),
    .cls_vec (cls_vec)
  );

  pwmsh_gsync gsync_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .cnt_zero  (cnt_zero),
    .gsync_req (gsync_req),
    .g_armed   (g_armed),
    .gsync_ack (gsync_ack)
  );

  for (genvar g = 0; g < NPARAM; g++) begin : g_slot
    pwmsh_slot #(.DW(DW), .SEL_W(SEL_W), .IDX(g)) slot_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .wr_sel   (wr_sel),
      .wr_data  (wr_data),
      .cnt_zero (cnt_zero),
      .g_armed  (g_armed),
      .cls      (cls_e'(cls_vec[2*g +: 2])),
      .act_q    (act_vals[g*DW +: DW]),
      .pend_q   (pend_flags[g])
    );
  end
endmodule

// File: rtl/pwmsh_ctrl_chk.sv
module pwmsh_ctrl_chk
  import pwmsh_pkg::*;
#(
  parameter int DW    = 16,
  parameter int SEL_W = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 wr_en,
  input logic [SEL_W-1:0]     wr_sel,
  input logic [DW-1:0]        wr_data,
  input logic                 cnt_zero,
  input logic                 gsync_ack,
  input logic [NPARAM*DW-1:0] act_vals,
  input logic [NPARAM-1:0]    pend_flags,
  input logic [MODE_W-1:0]    mode_q
);
  a_r11_act_needs_event: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(act_vals) |-> ($past(wr_en) || $past(cnt_zero)));

  a_r9_ack_after_zero: assert property (@(posedge clk) disable iff (!rst_n)
    gsync_ack |-> $past(cnt_zero));

  a_r2_ignored_sel: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel > SEL_W'(SEL_MODE) && !cnt_zero)
      |=> ($stable(act_vals) && $stable(pend_flags)));

  a_r3_imm_action_a: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == SEL_W'(N_SHORT) && !mode_q[1])
      |=> (act_vals[N_SHORT*DW +: DW] == $past(wr_data) && !pend_flags[N_SHORT]));

  for (genvar g = 0; g < NPARAM; g++) begin : g_pend
    a_r4_pend_rise: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pend_flags[g]) |-> $past(wr_en && wr_sel == SEL_W'(g)));
    a_r4_pend_fall: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pend_flags[g]) |-> $past(cnt_zero || (wr_en && wr_sel == SEL_W'(g))));
  end
endmodule

bind pwmsh_ctrl pwmsh_ctrl_chk #(.DW(DW), .SEL_W(SEL_W)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .wr_en      (wr_en),
  .wr_sel     (wr_sel),
  .wr_data    (wr_data),
  .cnt_zero   (cnt_zero),
  .gsync_ack  (gsync_ack),
  .act_vals   (act_vals),
  .pend_flags (pend_flags),
  .mode_q     (mode_q)
);

// File: tb/pwmsh_ctrl_tb_top.sv
module pwmsh_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 16;
  localparam int SW = 4;
  localparam int NP = 8;
  localparam int WATCHDOG = 20000;

  logic clk, rst_n, wr_en, cnt_zero, gsync_req;
  logic [SW-1:0] wr_sel;
  logic [DW-1:0] wr_data;
  logic gsync_ack;
  logic [NP*DW-1:0] act_vals;
  logic [NP-1:0] pend_flags;

  pwmsh_ctrl #(.DW(DW), .SEL_W(SW)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .cnt_zero(cnt_zero), .gsync_req(gsync_req), .gsync_ack(gsync_ack),
    .act_vals(act_vals), .pend_flags(pend_flags)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int n_cmp = 0, n_bad = 0;
  bit cmp_on = 0, done = 0;
  string cur_req = "R1";

  // behavioural reference model
  int m_act[NP], m_sh[NP], m_mode;
  bit m_pd[NP];
  bit m_greq, m_ack;

  function automatic int code_of(int p);
    if (p < 3) return ((m_mode >> (10 + p)) & 1) != 0 ? 3 : 2;
    return (m_mode >> (2 * (p - 3))) & 3;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int p = 0; p < NP; p++) begin m_act[p] = 0; m_sh[p] = 0; m_pd[p] = 0; end
      m_mode = 0; m_greq = 0; m_ack = 0;
    end else begin
      bit arm, w;
      int c;
      arm = m_greq || gsync_req;
      for (int p = 0; p < NP; p++) begin
        c = code_of(p);
        w = wr_en && (int'(wr_sel) == p);
        if (w) m_sh[p] = int'(wr_data);
        if (w && c < 2) begin
          m_act[p] = int'(wr_data); m_pd[p] = 0;
        end else begin
          if (w) m_pd[p] = 1;
          if (cnt_zero && m_pd[p] && (c != 3 || arm)) begin
            m_act[p] = m_sh[p]; m_pd[p] = 0;
          end
        end
      end
      if (wr_en && int'(wr_sel) == 8) m_mode = int'(wr_data) & 'h1FFF;
      m_ack  = cnt_zero && arm;
      m_greq = arm && !cnt_zero;
    end
  end

  always @(negedge clk) begin
    if (cmp_on && !done) begin
      for (int p = 0; p < NP; p++) begin
        n_cmp++;
        if (int'(act_vals[p*DW +: DW]) != m_act[p] || pend_flags[p] != m_pd[p]) begin
          n_bad++;
          $display("FAIL %s param %0d act/pend actual %h/%0d expected %h/%0d", cur_req, p,
                   act_vals[p*DW +: DW], pend_flags[p], m_act[p], m_pd[p]);
        end
      end
      n_cmp++;
      if (gsync_ack != m_ack) begin
        n_bad++;
        $display("FAIL %s gsync_ack actual %0d expected %0d", cur_req, gsync_ack, m_ack);
      end
    end
  end

  task automatic chk(string req, string what, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic int actv(int p);
    return int'(act_vals[p*DW +: DW]);
  endfunction

  task automatic step(bit we, int sel, int data, bit zero, bit req);
    wr_en = we; wr_sel = SW'(sel); wr_data = DW'(data); cnt_zero = zero; gsync_req = req;
    @(negedge clk);
    wr_en = 0; cnt_zero = 0; gsync_req = 0;
  endtask

  task automatic wr(int sel, int data); step(1, sel, data, 0, 0); endtask
  task automatic zero(); step(0, 0, 0, 1, 0); endtask

  initial begin
    wr_en = 0; wr_sel = '0; wr_data = '0; cnt_zero = 0; gsync_req = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "act_vals", int'(act_vals[31:0]) | int'(act_vals[127:96]), 0);
    chk("R1", "pend_flags", int'(pend_flags), 0);
    chk("R1", "gsync_ack", int'(gsync_ack), 0);
    rst_n = 1; cmp_on = 1;
    @(negedge clk);

    // R1 default modes: load local, action A immediate
    wr(0, 'h1111);
    chk("R1", "load pending", int'(pend_flags[0]), 1);
    chk("R1", "load held", actv(0), 0);
    wr(3, 'h3333);
    chk("R1", "actA immediate", actv(3), 'h3333);
    cur_req = "R4";
    zero();
    chk("R4", "load committed", actv(0), 'h1111);
    chk("R4", "load pend cleared", int'(pend_flags[0]), 0);

    // R3 immediate on all waveform parameters
    cur_req = "R3";
    for (int p = 3; p < 8; p++) begin
      wr(p, 'h0100 * p + 7);
      chk("R3", "immediate value", actv(p), 'h0100 * p + 7);
      chk("R3", "no pending", int'(pend_flags[p]), 0);
    end
    wr(8, 'h001);                 // R3 reserved code 1 on action A
    wr(3, 'hBEEF);
    chk("R3", "reserved code acts immediate", actv(3), 'hBEEF);

    // R4 / R6 local via mode register
    cur_req = "R4";
    wr(8, 'h2AA);
    wr(4, 'h4444);
    chk("R4", "actB pending", int'(pend_flags[4]), 1);
    chk("R4", "actB held", actv(4), 'h0407);
    zero();
    chk("R4", "actB committed", actv(4), 'h4444);

    // R7 overwrite
    cur_req = "R7";
    wr(5, 'hAAAA); wr(5, 'hBBBB);
    zero();
    chk("R7", "last value committed", actv(5), 'hBBBB);

    // R5 / R6 global
    cur_req = "R5";
    wr(8, 'h7FF);
    wr(0, 'hA0A0); wr(6, 'h6060);
    zero(); zero();
    chk("R5", "load held without request", actv(0), 'h1111);
    chk("R5", "rise still pending", int'(pend_flags[6]), 1);
    step(0, 0, 0, 0, 1);
    chk("R5", "request alone commits nothing", actv(6), 'h0607);
    chk("R9", "no ack without zero", int'(gsync_ack), 0);
    zero();
    chk("R5", "load committed", actv(0), 'hA0A0);
    chk("R6", "rise committed", actv(6), 'h6060);
    chk("R9", "ack pulse", int'(gsync_ack), 1);
    step(0, 0, 0, 0, 0);
    chk("R9", "ack one cycle", int'(gsync_ack), 0);
    cur_req = "R9";
    wr(6, 'h6161);
    zero();
    chk("R9", "latch cleared, value held", actv(6), 'h6060);
    step(0, 0, 0, 1, 1);          // request in the zero cycle
    chk("R9", "same-cycle request commits", actv(6), 'h6161);
    chk("R9", "same-cycle ack", int'(gsync_ack), 1);

    // R8 write with committing zero
    cur_req = "R8";
    wr(8, 'h2AA);
    wr(7, 'h7000);
    step(1, 7, 'h7777, 1, 0);
    chk("R8", "new data wins", actv(7), 'h7777);
    chk("R8", "pend clear", int'(pend_flags[7]), 0);

    // R10 mode changed to immediate while pending
    cur_req = "R10";
    wr(6, 'h6262);
    wr(8, 'h000);
    chk("R10", "still pending after mode change", int'(pend_flags[6]), 1);
    zero();
    chk("R10", "committed at zero", actv(6), 'h6262);

    // R2 ignored selects
    cur_req = "R2";
    wr(8, 'h2AA);
    for (int s = 9; s < 16; s++) wr(s, 'hFFFF);
    chk("R2", "no pending from ignored selects", int'(pend_flags), 0);
    chk("R2", "load unchanged", actv(0), 'hA0A0);

    // R11 random mix
    cur_req = "R11";
    for (int i = 0; i < 4000; i++) begin
      step(($urandom_range(0, 2) == 0), $urandom_range(0, 15), $urandom_range(0, 65535),
           ($urandom_range(0, 4) == 0), ($urandom_range(0, 6) == 0));
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      done = 1;
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule